// File: doc/BRIEF.md
# Interlaced Master Sync Generator

This block produces the active-low horizontal and vertical sync outputs of a video timing master for interlaced 525-line or 625-line video. It runs from a clock at twice the pixel rate: an internal phase bit lets the pixel counter advance on every second clock. Each clock, the pixel position, line position and 8-step field sequence are decoded into registered sync levels.

A standard-select input chooses the line length, the field lengths and the vertical sync shape. Fields alternate between a short field of N lines and a long field of N+1 lines. The second field of each pair places its vertical sync on half-line boundaries, which is what gives the interlace. A second input turns the vertical sync pin into an odd/even field flag. A one-clock pulse marks the colour-frame boundaries, so a downstream stage can realign its subcarrier phase. A sleep input forces the counters back to the start position and keeps both sync pins at their last driven levels.

Top module: `mss_master_sync`

## Requirements
- R1: While `rst` is high, `hsync_n` and `vsync_n` are 1, `frame_start` is 0 and `field_seq` is 0. The first clock edge with `rst` low decodes the start position: pixel 1 of line 1 of field index 0.
- R2: The pixel counter runs from 1 and advances on every second clock. It wraps after 858 pixels when `std_625`=0 and after 864 pixels when `std_625`=1 (parameters `PIX_525`, `PIX_625`). Each output reflects the position held during the clock edge that registers it.
- R3: `hsync_n` is 0 for pixels 1 to `HSYNC_PIX` (63 by default) of every line and 1 for all later pixels. This includes the last 20 pixels, which form the front porch.
- R4: Fields alternate between `FIELD_x` lines and `FIELD_x`+1 lines, starting with the short field (262/263 for 525-line mode, 312/313 for 625-line mode). `field_seq` counts the fields modulo 8, with index 0 as the first field after a restart.
- R5: When `std_625`=0 and `field_flag_en`=0, `vsync_n` is low for 3 lines. In even-index fields this runs from pixel 1 of line 1 to the end of line 3. In odd-index fields it runs from the line midpoint (pixel `PIX_525`/2+1) of line 1 to the midpoint of line 4.
- R6: When `std_625`=1 and `field_flag_en`=0, `vsync_n` is low for 2.5 lines. In even-index fields this runs from pixel 1 of line 1 to the midpoint of line 3. In odd-index fields it runs from the midpoint of line 1 to the end of line 3.
- R7: When `field_flag_en`=1, `vsync_n` is 1 during even-index fields (odd picture fields: field 1, 3, ...) and 0 during odd-index fields.
- R8: `frame_start` is high for exactly one clock, at pixel 1, line 1 of every field whose index is 0 or 4 when `std_625`=0, and only of index 0 when `std_625`=1.
- R9: While `sleep` is high, `hsync_n`, `vsync_n` and `field_seq` keep their last values, `frame_start` is 0, and the counters are held at the start position. After `sleep` falls, timing restarts exactly as after R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the pixel rate |
| rst | input | 1 | Synchronous active-high reset |
| sleep | input | 1 | Freeze outputs and hold counters at start |
| std_625 | input | 1 | 0 = 525-line timing, 1 = 625-line timing |
| field_flag_en | input | 1 | 1 = vertical sync pin shows field parity |
| hsync_n | output | 1 | Active-low horizontal sync |
| vsync_n | output | 1 | Active-low vertical sync or field flag |
| field_seq | output | 3 | Field index within the 8-field sequence |
| frame_start | output | 1 | One-clock colour-frame boundary pulse |

## Verification
A wrong pixel phase or pixel count moves the falling edge of `hsync_n` on the very next line, so the error shows within one line time. A wrong line count or a wrong field-length choice shifts `field_seq` and the vertical sync window at the next field boundary. An error in the half-line window shows up only in the odd-index field of a pair, which is why every run covers full 8-field sequences in both standards. A frozen or leaking state during sleep appears as a changed sync level during sleep, or as a restart that does not begin at the start position.

// File: rtl/mss_pkg.sv
package mss_pkg;

    typedef enum logic {
        STD_525 = 1'b0,
        STD_625 = 1'b1
    } line_std_e;

    localparam int SEQ_W = 3;

    typedef struct packed {
        logic             hs_n;
        logic             vs_n;
        logic             frame_start;
        logic [SEQ_W-1:0] field_seq;
    } sync_out_t;

    localparam sync_out_t SYNC_IDLE = '{hs_n: 1'b1, vs_n: 1'b1, frame_start: 1'b0, field_seq: '0};

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // frame boundary: every 4 fields for 525-line, every 8 for 625-line
    function automatic logic is_frame_field(input line_std_e std, input logic [SEQ_W-1:0] seq);
        if (std == STD_625) return (seq == '0);
        return (seq[1:0] == 2'b00);
    endfunction

endpackage

// File: rtl/mss_pixel_timer.sv
module mss_pixel_timer
    import mss_pkg::*;
#(
    parameter int PIX_525 = 858,
    parameter int PIX_625 = 864,
    localparam int HW = $clog2(max2(PIX_525, PIX_625) + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hold,
    input  line_std_e     std,
    output logic [HW-1:0] hcnt,
    output logic          phase,
    output logic          line_end
);

    localparam logic [HW-1:0] TOT_A = HW'(PIX_525);
    localparam logic [HW-1:0] TOT_B = HW'(PIX_625);
    localparam logic [HW-1:0] ONE   = HW'(1);

    logic [HW-1:0] htot;

    always_comb begin
        htot     = (std == STD_625) ? TOT_B : TOT_A;
        line_end = phase && (hcnt >= htot);
    end

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            phase <= 1'b0;
            hcnt  <= ONE;
        end else begin
            phase <= ~phase;
            if (phase) begin
                hcnt <= (hcnt >= htot) ? ONE : hcnt + ONE;
            end
        end
    end

    // R2: counter stays inside 1..line length
    a_r2_hcnt_range: assert property (@(posedge clk) disable iff (rst)
        (hcnt >= ONE) && (hcnt <= htot));

    // R2: no advance on the first clock of a pixel pair
    a_r2_pair_step: assert property (@(posedge clk) disable iff (rst)
        (!phase && !hold && !rst) |=> $stable(hcnt));

endmodule

// File: rtl/mss_line_timer.sv
module mss_line_timer
    import mss_pkg::*;
#(
    parameter int FIELD_525 = 262,
    parameter int FIELD_625 = 312,
    localparam int VW = $clog2(max2(FIELD_525, FIELD_625) + 2)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  line_std_e        std,
    input  logic             line_end,
    output logic [VW-1:0]    vcnt,
    output logic [SEQ_W-1:0] seq
);

    localparam logic [VW-1:0] BASE_A = VW'(FIELD_525);
    localparam logic [VW-1:0] BASE_B = VW'(FIELD_625);
    localparam logic [VW-1:0] ONE    = VW'(1);

    logic [VW-1:0] flen;
    logic          field_end;

    always_comb begin
        // short field at even index, long field at odd index
        flen      = ((std == STD_625) ? BASE_B : BASE_A) + VW'(seq[0]);
        field_end = line_end && (vcnt >= flen);
    end

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            vcnt <= ONE;
            seq  <= '0;
        end else if (line_end) begin
            if (field_end) begin
                vcnt <= ONE;
                seq  <= seq + SEQ_W'(1);
            end else begin
                vcnt <= vcnt + ONE;
            end
        end
    end

    // R4: line counter inside 1..field length
    a_r4_vcnt_range: assert property (@(posedge clk) disable iff (rst)
        (vcnt >= ONE) && (vcnt <= flen));

    // R4: field index steps by one at the field boundary
    a_r4_seq_step: assert property (@(posedge clk) disable iff (rst)
        (field_end && !hold && !rst) |=> (seq == $past(seq) + SEQ_W'(1)) && (vcnt == ONE));

    // R4: field index only moves at a field boundary
    a_r4_seq_quiet: assert property (@(posedge clk) disable iff (rst)
        (!field_end && !hold && !rst) |=> $stable(seq));

endmodule

// File: rtl/mss_sync_decode.sv
module mss_sync_decode
    import mss_pkg::*;
#(
    parameter int PIX_525     = 858,
    parameter int PIX_625     = 864,
    parameter int HSYNC_PIX   = 63,
    parameter int FIELD_525   = 262,
    parameter int FIELD_625   = 312,
    parameter int VS_HALF_525 = 6,
    parameter int VS_HALF_625 = 5,
    localparam int HW = $clog2(max2(PIX_525, PIX_625) + 1),
    localparam int VW = $clog2(max2(FIELD_525, FIELD_625) + 2)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  line_std_e        std,
    input  logic             field_flag_en,
    input  logic [HW-1:0]    hcnt,
    input  logic             phase,
    input  logic [VW-1:0]    vcnt,
    input  logic [SEQ_W-1:0] seq,
    output sync_out_t        sync_q
);

    localparam logic [HW-1:0] HALF_A = HW'(PIX_525 / 2);
    localparam logic [HW-1:0] HALF_B = HW'(PIX_625 / 2);
    localparam logic [HW-1:0] HS_END = HW'(HSYNC_PIX);
    localparam logic [VW:0]   LEN_A  = (VW+1)'(VS_HALF_525);
    localparam logic [VW:0]   LEN_B  = (VW+1)'(VS_HALF_625);

    logic [HW-1:0] half;
    logic [VW:0]   half_idx;
    logic [VW:0]   vs_first;
    logic [VW:0]   vs_last;
    logic          hs_act;
    logic          vs_act;
    logic          frame_hit;
    sync_out_t     sync_d;

    always_comb begin
        half      = (std == STD_625) ? HALF_B : HALF_A;
        // position in half-lines from the top of the field
        half_idx  = {vcnt - VW'(1), 1'b0} + (VW+1)'(hcnt > half);
        // odd-index fields start vertical sync half a line late
        vs_first  = (VW+1)'(seq[0]);
        vs_last   = vs_first + ((std == STD_625) ? LEN_B : LEN_A);
        vs_act    = (half_idx >= vs_first) && (half_idx < vs_last);
        hs_act    = (hcnt <= HS_END);
        frame_hit = !phase && (hcnt == HW'(1)) && (vcnt == VW'(1)) && is_frame_field(std, seq);

        sync_d.hs_n        = ~hs_act;
        sync_d.vs_n        = field_flag_en ? ~seq[0] : ~vs_act;
        sync_d.frame_start = frame_hit;
        sync_d.field_seq   = seq;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= SYNC_IDLE;
        end else if (hold) begin
            sync_q.frame_start <= 1'b0;
        end else begin
            sync_q <= sync_d;
        end
    end

    // R1: reset drives idle levels
    a_r1_idle: assert property (@(posedge clk)
        rst |=> (sync_q.hs_n && sync_q.vs_n && !sync_q.frame_start && (sync_q.field_seq == '0)));

    // R9: sleep freezes both sync pins and the field index
    a_r9_freeze: assert property (@(posedge clk) disable iff (rst)
        (hold && !rst) |=> ($stable(sync_q.hs_n) && $stable(sync_q.vs_n)
                            && $stable(sync_q.field_seq) && !sync_q.frame_start));

    // R8: frame pulse lasts one clock
    a_r8_single: assert property (@(posedge clk) disable iff (rst)
        sync_q.frame_start |=> !sync_q.frame_start);

    // R7: field flag follows the parity of the field index
    a_r7_flag: assert property (@(posedge clk) disable iff (rst)
        (field_flag_en && !hold && !rst) |=> (sync_q.vs_n == ~$past(seq[0])));

    // R3: horizontal sync low at pixel 1 of every line
    a_r3_line_head: assert property (@(posedge clk) disable iff (rst)
        ((hcnt == HW'(1)) && !hold && !rst) |=> !sync_q.hs_n);

endmodule

// File: rtl/mss_master_sync.sv
module mss_master_sync
    import mss_pkg::*;
#(
    parameter int PIX_525     = 858,
    parameter int PIX_625     = 864,
    parameter int HSYNC_PIX   = 63,
    parameter int FIELD_525   = 262,
    parameter int FIELD_625   = 312,
    parameter int VS_HALF_525 = 6,
    parameter int VS_HALF_625 = 5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sleep,
    input  logic       std_625,
    input  logic       field_flag_en,
    output logic       hsync_n,
    output logic       vsync_n,
    output logic [2:0] field_seq,
    output logic       frame_start
);

    localparam int HW = $clog2(max2(PIX_525, PIX_625) + 1);
    localparam int VW = $clog2(max2(FIELD_525, FIELD_625) + 2);

    line_std_e        std;
    logic [HW-1:0]    hcnt;
    logic             phase;
    logic             line_end;
    logic [VW-1:0]    vcnt;
    logic [SEQ_W-1:0] seq;
    sync_out_t        sync_q;

    assign std = line_std_e'(std_625);

    mss_pixel_timer #(
        .PIX_525 (PIX_525),
        .PIX_625 (PIX_625)
    ) u_pix (
        .clk      (clk),
        .rst      (rst),
        .hold     (sleep),
        .std      (std),
        .hcnt     (hcnt),
        .phase    (phase),
        .line_end (line_end)
    );

    mss_line_timer #(
        .FIELD_525 (FIELD_525),
        .FIELD_625 (FIELD_625)
    ) u_line (
        .clk      (clk),
        .rst      (rst),
        .hold     (sleep),
        .std      (std),
        .line_end (line_end),
        .vcnt     (vcnt),
        .seq      (seq)
    );

    mss_sync_decode #(
        .PIX_525     (PIX_525),
        .PIX_625     (PIX_625),
        .HSYNC_PIX   (HSYNC_PIX),
        .FIELD_525   (FIELD_525),
        .FIELD_625   (FIELD_625),
        .VS_HALF_525 (VS_HALF_525),
        .VS_HALF_625 (VS_HALF_625)
    ) u_dec (
        .clk           (clk),
        .rst           (rst),
        .hold          (sleep),
        .std           (std),
        .field_flag_en (field_flag_en),
        .hcnt          (hcnt),
        .phase         (phase),
        .vcnt          (vcnt),
        .seq           (seq),
        .sync_q        (sync_q)
    );

    assign hsync_n     = sync_q.hs_n;
    assign vsync_n     = sync_q.vs_n;
    assign field_seq   = sync_q.field_seq;
    assign frame_start = sync_q.frame_start;

endmodule

// File: tb/mss_master_sync_bench.sv
module mss_master_sync_bench;

    localparam int HA  = 20;
    localparam int HB  = 24;
    localparam int HSW = 5;
    localparam int FA  = 7;
    localparam int FB  = 9;
    localparam int VLA = 6;
    localparam int VLB = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sleep = 1'b0;
    logic       std_625 = 1'b0;
    logic       field_flag_en = 1'b0;
    logic       hsync_n;
    logic       vsync_n;
    logic [2:0] field_seq;
    logic       frame_start;

    int checks = 0;
    int errors = 0;
    int t = 0;
    bit done = 0;

    always #5 clk = ~clk;

    mss_master_sync #(
        .PIX_525 (HA), .PIX_625 (HB), .HSYNC_PIX (HSW),
        .FIELD_525 (FA), .FIELD_625 (FB),
        .VS_HALF_525 (VLA), .VS_HALF_625 (VLB)
    ) u_mss_master_sync (
        .clk (clk), .rst (rst), .sleep (sleep), .std_625 (std_625),
        .field_flag_en (field_flag_en), .hsync_n (hsync_n), .vsync_n (vsync_n),
        .field_seq (field_seq), .frame_start (frame_start)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at t=%0d: actual %0d expected %0d", req, t, act, exp);
        end
    endtask

    // expected outputs for position index tt (clocks since restart)
    task automatic check_pos(input int tt);
        int h_tot, n, p, ph, line, h, pl, pair, r, v, seq, hidx, len, st;
        bit second, vs_act, e_hs, e_vs, e_fr;
        h_tot  = std_625 ? HB : HA;
        n      = std_625 ? FB : FA;
        p      = tt / 2;
        ph     = tt % 2;
        line   = p / h_tot;
        h      = p % h_tot + 1;
        pl     = 2 * n + 1;
        pair   = line / pl;
        r      = line % pl;
        second = (r >= n);
        v      = second ? r - n + 1 : r + 1;
        seq    = (2 * pair + int'(second)) % 8;
        hidx   = 2 * (v - 1) + ((h > h_tot / 2) ? 1 : 0);
        st     = int'(second);
        len    = std_625 ? VLB : VLA;
        vs_act = (hidx >= st) && (hidx < st + len);
        e_hs   = !(h <= HSW);
        e_vs   = field_flag_en ? (seq % 2 == 0) : !vs_act;
        e_fr   = (ph == 0) && (h == 1) && (v == 1) &&
                 (std_625 ? (seq == 0) : (seq % 4 == 0));
        chk("R2/R3 hsync_n", int'(hsync_n), int'(e_hs));
        if (field_flag_en)  chk("R7 vsync_n field flag", int'(vsync_n), int'(e_vs));
        else if (std_625)   chk("R6 vsync_n 625", int'(vsync_n), int'(e_vs));
        else                chk("R5 vsync_n 525", int'(vsync_n), int'(e_vs));
        chk("R8 frame_start", int'(frame_start), int'(e_fr));
        chk("R4 field_seq", int'(field_seq), seq);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
            check_pos(t);
            t++;
        end
        @(negedge clk);
    endtask

    task automatic restart(input bit s625, input bit ff);
        @(negedge clk);
        rst = 1'b1;
        std_625 = s625;
        field_flag_en = ff;
        repeat (3) @(negedge clk);
        // R1: idle levels under reset
        chk("R1 hsync_n", int'(hsync_n), 1);
        chk("R1 vsync_n", int'(vsync_n), 1);
        chk("R1 frame_start", int'(frame_start), 0);
        chk("R1 field_seq", int'(field_seq), 0);
        rst = 1'b0;
        t = 0;
    endtask

    initial begin
        int seq_a, len525, len625;
        bit hs_k, vs_k;
        logic [2:0] fs_k;
        len525 = 8 * (2 * FA + 1) * HA;   // 4 field pairs, in clocks
        len625 = 8 * (2 * FB + 1) * HB;

        // R5, R4, R8: 525-line, two full 8-field sequences
        restart(1'b0, 1'b0);
        run(2 * len525);
        // R6: 625-line, two full sequences
        restart(1'b1, 1'b0);
        run(2 * len625);
        // R7: field flag in both standards, switched mid-run
        restart(1'b0, 1'b1);
        run(len525);
        field_flag_en = 1'b0;
        run(len525 / 2);
        restart(1'b1, 1'b1);
        run(len625);

        // R9: sleep mid-field freezes outputs, restart from start position
        restart(1'b1, 1'b0);
        run(1000 + 7);
        sleep = 1'b1;
        hs_k = hsync_n;
        vs_k = vsync_n;
        fs_k = field_seq;
        for (int i = 0; i < 40; i++) begin
            @(posedge clk);
            #1;
            chk("R9 hsync_n held", int'(hsync_n), int'(hs_k));
            chk("R9 vsync_n held", int'(vsync_n), int'(vs_k));
            chk("R9 field_seq held", int'(field_seq), int'(fs_k));
            chk("R9 frame_start low", int'(frame_start), 0);
        end
        @(negedge clk);
        sleep = 1'b0;
        t = 0;
        run(len625 / 2);
        // R9 in 525-line mode with the field flag on
        std_625 = 1'b0;
        restart(1'b0, 1'b1);
        run(333);
        sleep = 1'b1;
        vs_k = vsync_n;
        repeat (10) @(posedge clk);
        #1;
        chk("R9 vsync_n flag held", int'(vsync_n), int'(vs_k));
        @(negedge clk);
        sleep = 1'b0;
        t = 0;
        seq_a = 0;
        run(len525);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired after %0d checks", checks);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule